// File: doc/BRIEF.md
# Clock Synthesizer Configuration Register

This block holds the programming word of a PLL clock synthesizer: a 9-bit feedback multiplier value, a 2-bit post-divide select and a 3-bit test-node select. Two paths can write the word. A parallel path takes the multiplier and post-divide select from static input pins when its load strobe goes from low to high. A three-wire serial path shifts bits into a 14-bit register on each rising serial clock and copies the whole register into the word when its load strobe goes from high to low.

All interface pins are treated as asynchronous to the single system clock. Each pin passes through two synchronizing flops, and edges are found in the system clock domain. The block drives the latched fields and a one-hot form of the post-divide ratio, which the divider logic downstream uses.

The parallel path has precedence. While its strobe is low, the serial load is shut out. When both paths produce a load in the same cycle, the parallel values are taken.

Top module: `synth_cfg_reg`

## Requirements
- R1: Each rising edge on `ser_clk` shifts the 14-bit serial register left by one bit. The synchronized `ser_dat` value enters bit 0.
- R2: The serial word is sent most significant bit first, in the order test select bits 2..0, post-divide select bits 1..0, multiplier bits 8..0. After 14 shifts, test bit 2 is in register bit 13 and multiplier bit 0 is in bit 0.
- R3: A falling edge on `ser_ld` while `par_ld` is high copies register bits 13:11 to `cfg_t`, bits 10:9 to `cfg_n` and bits 8:0 to `cfg_m`.
- R4: A rising edge on `par_ld` copies `par_m` to `cfg_m` and `par_n` to `cfg_n`. These pins must stay stable for four clocks after the strobe edge.
- R5: A parallel load sets `cfg_t` to 000, which is the inactive test selection.
- R6: A falling edge on `ser_ld` while `par_ld` is low leaves all latched fields unchanged.
- R7: When a `par_ld` rising edge and a `ser_ld` falling edge reach the block in the same cycle, only the parallel load takes effect, and `cfg_t` becomes 000.
- R8: `div_sel` is one-hot and gives the post-divide ratio: `cfg_n` 00 gives 0001 (divide by 1), 01 gives 0010 (by 2), 10 gives 0100 (by 4), 11 gives 1000 (by 8).
- R9: Reset (`rst_n` low) sets `cfg_m` to all ones and `cfg_n` to 11, which is the pattern that undriven parallel pins read as. Reset also sets `cfg_t` to 000 and clears the serial register.
- R10: Shifting without a load strobe edge does not change any latched field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_m | input | 9 | Parallel multiplier value |
| par_n | input | 2 | Parallel post-divide select |
| par_ld | input | 1 | Parallel load strobe, captures on rising edge |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load strobe, captures on falling edge |
| cfg_m | output | 9 | Latched multiplier value |
| cfg_n | output | 2 | Latched post-divide select |
| cfg_t | output | 3 | Latched test-node select |
| div_sel | output | 4 | One-hot post-divide ratio |

## Verification
The hardest case to reach is a parallel rising edge and a serial falling edge that arrive in the same system cycle. The synchronizers add latency, so the two pin edges must be driven at the same instant. The bench has a directed step that changes both strobes on one falling clock edge, after a full serial word has been shifted in. This gives a collision in which the serial word differs from the parallel word. Random sequences of shifts, loads and strobe levels then check that the serial load is blocked while the parallel strobe is low.

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           par_ld,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t,
  output logic [(1<<N_W)-1:0] div_sel
);
  localparam int W_W = M_W + N_W + T_W;

  // pin order: {par_ld, ser_ld, ser_dat, ser_clk}
  logic [3:0] sy1, sy2, prv;
  logic [W_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      prv <= '0;
    end else begin
      sy1 <= {par_ld, ser_ld, ser_dat, ser_clk};
      sy2 <= sy1;
      prv <= sy2;
    end

  logic clk_rise, ld_fall, par_rise, par_lvl, dat;
  assign clk_rise = sy2[0] & ~prv[0];
  assign dat      = sy2[1];
  assign ld_fall  = ~sy2[2] & prv[2];
  assign par_rise = sy2[3] & ~prv[3];
  assign par_lvl  = sy2[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sr <= '0;
    else if (clk_rise) sr <= {sr[W_W-2:0], dat};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_m <= '1;
      cfg_n <= '1;
      cfg_t <= '0;
    end else if (par_rise) begin
      cfg_m <= par_m;
      cfg_n <= par_n;
      cfg_t <= '0;
    end else if (ld_fall && par_lvl) begin
      {cfg_t, cfg_n, cfg_m} <= sr;
    end

  assign div_sel = (1 << N_W)'(1) << cfg_n;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise |=> sr == {$past(sr[W_W-2:0]), $past(dat)}); // R1
  AST_SER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && par_lvl && !par_rise) |=> {cfg_t, cfg_n, cfg_m} == $past(sr)); // R3
  AST_PAR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    par_rise |=> (cfg_m == $past(par_m) && cfg_n == $past(par_n) && cfg_t == '0)); // R5
  AST_SER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && !par_lvl) |=> $stable({cfg_t, cfg_n, cfg_m})); // R6
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_fall && !par_rise) |=> $stable({cfg_t, cfg_n, cfg_m})); // R10
  AST_DIV_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(div_sel) && div_sel[cfg_n]); // R8
endmodule

// File: tb/synth_cfg_reg_tb.sv
module synth_cfg_reg_tb_top;
  logic clk = 0, rst_n = 0;
  logic [8:0] par_m = '1;
  logic [1:0] par_n = '1;
  logic par_ld = 0, ser_clk = 0, ser_dat = 0, ser_ld = 0;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;
  logic [3:0] div_sel;

  int checks = 0, errors = 0;
  logic [8:0] e_m;
  logic [1:0] e_n;
  logic [2:0] e_t;
  logic [13:0] e_sr;

  always #2 clk = ~clk;

  synth_cfg_reg dut_i (.clk(clk), .rst_n(rst_n), .par_m(par_m), .par_n(par_n),
    .par_ld(par_ld), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .div_sel(div_sel));

  function automatic logic [3:0] exp_div(input logic [1:0] n);
    case (n)
      2'b00: return 4'b0001;
      2'b01: return 4'b0010;
      2'b10: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check(input string req);
    logic [17:0] act, exp;
    act = {cfg_t, cfg_n, cfg_m, div_sel};
    exp = {e_t, e_n, e_m, exp_div(e_n)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual t=%b n=%b m=%h div=%b expected t=%b n=%b m=%h div=%b",
        req, cfg_t, cfg_n, cfg_m, div_sel, e_t, e_n, e_m, exp_div(e_n));
    end
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b; settle();
    ser_clk = 1; settle();
    ser_clk = 0; settle();
    e_sr = {e_sr[12:0], b};
  endtask

  task automatic ser_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic ser_load();
    ser_ld = 1; settle();
    ser_ld = 0; settle();
    if (par_ld) {e_t, e_n, e_m} = e_sr;
  endtask

  task automatic par_load(input logic [8:0] m, input logic [1:0] n);
    par_m = m; par_n = n;
    if (par_ld) begin par_ld = 0; settle(); end
    par_ld = 1; settle();
    e_m = m; e_n = n; e_t = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    e_m = '1; e_n = '1; e_t = 0; e_sr = 0;
    repeat (3) @(negedge clk);
    check("R9 reset state");
    rst_n = 1; settle();
    check("R9 after release");
    par_ld = 1; settle();
    e_m = '1; e_n = '1; e_t = 0;
    check("R9 parallel default");
    ser_load();
    check("R9 shift register cleared");
    for (int n = 0; n < 4; n++) begin
      par_load(9'h0A5 + 9'(n), 2'(n));
      check("R8 R4 decode");
    end
    ser_word({3'b101, 2'b10, 9'h13C});
    check("R10 shift without load");
    ser_load();
    check("R2 R3 serial word order");
    par_load(9'h055, 2'b01);
    check("R5 test field cleared");
    ser_word({3'b011, 2'b11, 9'h1E1});
    par_ld = 0; settle();
    ser_load();
    check("R6 serial blocked");
    par_m = 9'h0F0; par_n = 2'b00;
    settle();
    par_ld = 1; ser_ld = 1; settle();
    par_ld = 0; settle();
    par_ld = 1; ser_ld = 0; settle();
    e_m = 9'h0F0; e_n = 2'b00; e_t = 0;
    check("R7 parallel wins");
    ser_load();
    {e_t, e_n, e_m} = e_sr;
    check("R1 R3 serial after collision");
    for (int k = 0; k < 40; k++) begin
      case ($urandom_range(0, 4))
        0: begin par_load(9'($urandom), 2'($urandom)); check("R4 random parallel"); end
        1: begin ser_word(14'($urandom)); check("R10 random shift"); end
        2: begin ser_bit(1'($urandom)); check("R1 random bit"); end
        3: begin ser_load(); check(par_ld ? "R3 random serial" : "R6 random blocked"); end
        default: begin par_ld = ~par_ld; settle(); if (par_ld) begin e_m = par_m; e_n = par_n; e_t = 0; end check("R4 R6 strobe toggle"); end
      endcase
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule